// File: doc/BRIEF.md
# Memory-card command engine with SPI/native strap

This block is the command-side state machine of a memory card model. A host-side front end hands it commands that are already decoded: a 6-bit index and a flag that marks an application-specific command. The block updates the card's operating state and reports, one cycle later, which response format applies, together with a 32-bit status word. No block storage is modelled. The only data the card can return are its two 16-byte identity registers: the card-specific data (CSD) and the card identification (CID). They are streamed out one byte per read request.

A strap input selects between SPI operation and native bus operation, and the strap changes which commands are legal. In SPI mode the identification handshake of the native bus is refused. A single op-condition command then moves the card straight to the transfer state. Register reads become data-phase transfers that the host pulls byte by byte. In native mode the card walks through ready, identification and standby, and answers register reads with a long response instead. The strap is meant to be tied or changed only while reset is held. Because the block takes no command argument, card-address matching is not modelled.

Top module: `sdc_spi_core`

## Requirements
- R1: After reset, `card_status` is zero (state field 0 = idle), `rsp_valid`, `rd_valid` and `data_ready` are low. Bits other than 22 (illegal flag) and 12:9 (state) of `card_status` always read zero.
- R2: Index 0 (not application) returns the card to idle from any state and clears the illegal flag. The response is R1 (code 1) in SPI mode and none (code 0) in native mode. `rsp_valid` is high for exactly the cycle after `cmd_valid`.
- R3: Index 1 in SPI mode moves the card to transfer (state 4) with R1. In native mode it is illegal.
- R4: Application index 41 in SPI mode moves the card to transfer with R1. In native mode it moves idle to ready (state 1) with R3 (code 3), and is illegal in any other state.
- R5: In SPI mode, indices 2, 3, 4, 6, 7, 11, 15 and 26 (refused) and 24, 25, 27 and 42 (recognised but unsupported) set the illegal flag (bit 22), answer with code 0 and leave the state unchanged.
- R6: In native mode, the following transitions apply. Index 2 moves ready to identification (2) with R2 (code 2). Index 3 moves identification or standby to standby (3) with R6 (code 4). Index 7 toggles standby and transfer with R1. Indices 9 and 10 in standby answer R2 with no state change. Indices 4, 6, 11, 15, 24 to 27 and 42 answer R1 with no state change. Any out-of-state use is illegal.
- R7: In SPI mode in transfer, index 9 (CSD) or 10 (CID) enters sending-data (state 5) with R1 and rewinds the byte offset. In any other state it is illegal. `data_ready` is high exactly in sending-data.
- R8: In sending-data, each `rd_req` yields `rd_valid` one cycle later with the next register byte, starting with the most significant byte of the parameter value. After the 16th byte the card is back in transfer. A `rd_req` in any other state gives no `rd_valid` and changes nothing.
- R9: When `cmd_valid` and `rd_req` are high in the same cycle, the command is executed and the read is dropped, without advancing the byte offset.
- R10: Index 13 answers R1 with no state change in both modes. Any other index not named above, and any application index other than 41, is illegal.
- R11: The illegal flag stays set across later legal commands until index 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_mode | input | 1 | Strap: 1 = SPI operation, 0 = native bus |
| cmd_valid | input | 1 | A decoded command is presented this cycle |
| cmd_idx | input | 6 | Command index |
| cmd_app | input | 1 | Command is an application-specific one |
| rd_req | input | 1 | Pull one data byte |
| rsp_valid | output | 1 | Command completed last cycle |
| rsp_type | output | 3 | 0 none, 1 R1, 2 R2, 3 R3, 4 R6 |
| card_status | output | 32 | Illegal flag at bit 22, state at 12:9 |
| rd_valid | output | 1 | `rd_data` carries a byte |
| rd_data | output | 8 | Register byte |
| data_ready | output | 1 | Card is in sending-data |

## Verification
Every result is registered once. The response type and updated status are due on the clock edge after the one that sees `cmd_valid`. A data byte is due on the edge after the one that sees `rd_req`. `card_status` and `data_ready` follow the state register and change on that same edge. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and samples all outputs there, half a period after the single edge that produced them. A shadow model advances by exactly one step per stimulus, so each expected value lines up with that one edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_READY = 4'd1,
        ST_IDENT = 4'd2,
        ST_STBY  = 4'd3,
        ST_TRAN  = 4'd4,
        ST_DATA  = 4'd5,
        ST_RCV   = 4'd6
    } card_st_e;

    typedef enum logic [2:0] {
        RSP_NONE = 3'd0,
        RSP_R1   = 3'd1,
        RSP_R2   = 3'd2,
        RSP_R3   = 3'd3,
        RSP_R6   = 3'd4
    } rsp_e;

    localparam int STATUS_W  = 32;
    localparam int ILL_BIT   = 22;
    localparam int ST_LSB    = 9;

    localparam logic [5:0] IX_RESET   = 6'd0;
    localparam logic [5:0] IX_OPCOND  = 6'd1;
    localparam logic [5:0] IX_ALLID   = 6'd2;
    localparam logic [5:0] IX_ADDR    = 6'd3;
    localparam logic [5:0] IX_DSR     = 6'd4;
    localparam logic [5:0] IX_SWFN    = 6'd6;
    localparam logic [5:0] IX_SELECT  = 6'd7;
    localparam logic [5:0] IX_RD_CSD  = 6'd9;
    localparam logic [5:0] IX_RD_CID  = 6'd10;
    localparam logic [5:0] IX_STREAM  = 6'd11;
    localparam logic [5:0] IX_STATUS  = 6'd13;
    localparam logic [5:0] IX_SLEEP   = 6'd15;
    localparam logic [5:0] IX_WR1     = 6'd24;
    localparam logic [5:0] IX_WRN     = 6'd25;
    localparam logic [5:0] IX_PRG_ID  = 6'd26;
    localparam logic [5:0] IX_PRG_CSD = 6'd27;
    localparam logic [5:0] IX_LOCK    = 6'd42;
    localparam logic [5:0] IX_APP_OP  = 6'd41;

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic       spi_i,
    input  logic       app_i,
    input  logic [5:0] idx_i,
    input  card_st_e   cur_i,
    output card_st_e   nxt_o,
    output logic       ill_o,
    output rsp_e       rsp_o,
    output logic       load_o,
    output logic       cid_o,
    output logic       clr_o
);

    always_comb begin
        nxt_o  = cur_i;
        ill_o  = 1'b0;
        rsp_o  = RSP_NONE;
        load_o = 1'b0;
        cid_o  = 1'b0;
        clr_o  = 1'b0;
        if (app_i) begin
            if (idx_i == IX_APP_OP) begin
                if (spi_i) begin
                    nxt_o = ST_TRAN;
                    rsp_o = RSP_R1;
                end else if (cur_i == ST_IDLE) begin
                    nxt_o = ST_READY;
                    rsp_o = RSP_R3;
                end else begin
                    ill_o = 1'b1;
                end
            end else begin
                ill_o = 1'b1;
            end
        end else begin
            case (idx_i)
                IX_RESET: begin
                    nxt_o = ST_IDLE;
                    clr_o = 1'b1;
                    rsp_o = spi_i ? RSP_R1 : RSP_NONE;
                end
                IX_OPCOND: begin
                    if (spi_i) begin
                        nxt_o = ST_TRAN;
                        rsp_o = RSP_R1;
                    end else begin
                        ill_o = 1'b1;
                    end
                end
                IX_ALLID: begin
                    if (!spi_i && cur_i == ST_READY) begin
                        nxt_o = ST_IDENT;
                        rsp_o = RSP_R2;
                    end else begin
                        ill_o = 1'b1;
                    end
                end
                IX_ADDR: begin
                    if (!spi_i && (cur_i == ST_IDENT || cur_i == ST_STBY)) begin
                        nxt_o = ST_STBY;
                        rsp_o = RSP_R6;
                    end else begin
                        ill_o = 1'b1;
                    end
                end
                IX_SELECT: begin
                    if (!spi_i && cur_i == ST_STBY) begin
                        nxt_o = ST_TRAN;
                        rsp_o = RSP_R1;
                    end else if (!spi_i && cur_i == ST_TRAN) begin
                        nxt_o = ST_STBY;
                        rsp_o = RSP_R1;
                    end else begin
                        ill_o = 1'b1;
                    end
                end
                IX_DSR, IX_SWFN, IX_STREAM, IX_SLEEP, IX_PRG_ID,
                IX_WR1, IX_WRN, IX_PRG_CSD, IX_LOCK: begin
                    if (spi_i) begin
                        ill_o = 1'b1;
                    end else begin
                        rsp_o = RSP_R1;
                    end
                end
                IX_RD_CSD, IX_RD_CID: begin
                    if (spi_i && cur_i == ST_TRAN) begin
                        nxt_o  = ST_DATA;
                        load_o = 1'b1;
                        cid_o  = (idx_i == IX_RD_CID);
                        rsp_o  = RSP_R1;
                    end else if (!spi_i && cur_i == ST_STBY) begin
                        rsp_o = RSP_R2;
                    end else begin
                        ill_o = 1'b1;
                    end
                end
                IX_STATUS: begin
                    rsp_o = RSP_R1;
                end
                default: begin
                    ill_o = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdc_reg_bytes.sv
module sdc_reg_bytes #(
    parameter int                   NBYTES  = 16,
    parameter int                   OW      = $clog2(NBYTES),
    parameter logic [8*NBYTES-1:0]  CSD_VAL = '0,
    parameter logic [8*NBYTES-1:0]  CID_VAL = '0
) (
    input  logic          sel_cid_i,
    input  logic [OW-1:0] ofs_i,
    output logic [7:0]    byte_o
);

    logic [7:0] csd_b [NBYTES];
    logic [7:0] cid_b [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_split
        assign csd_b[g] = CSD_VAL[8*(NBYTES-1-g) +: 8];
        assign cid_b[g] = CID_VAL[8*(NBYTES-1-g) +: 8];
    end

    always_comb begin
        byte_o = sel_cid_i ? cid_b[ofs_i] : csd_b[ofs_i];
    end

endmodule

// File: rtl/sdc_spi_core.sv
module sdc_spi_core
    import sdc_pkg::*;
#(
    parameter int                  NBYTES  = 16,
    parameter logic [8*NBYTES-1:0] CSD_VAL = 128'h400E_0032_5B59_0000_1D8A_7F80_0A40_0001,
    parameter logic [8*NBYTES-1:0] CID_VAL = 128'h0353_4453_4430_3847_8012_3456_7800_C5A1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_mode,
    input  logic        cmd_valid,
    input  logic [5:0]  cmd_idx,
    input  logic        cmd_app,
    input  logic        rd_req,
    output logic        rsp_valid,
    output logic [2:0]  rsp_type,
    output logic [31:0] card_status,
    output logic        rd_valid,
    output logic [7:0]  rd_data,
    output logic        data_ready
);

    localparam int            OW       = $clog2(NBYTES);
    localparam logic [OW-1:0] OFS_LAST = OW'(NBYTES - 1);

    typedef struct packed {
        card_st_e      st;
        logic          ill;
        logic          src_cid;
        logic [OW-1:0] ofs;
        logic          rsp_v;
        rsp_e          rsp;
        logic          rd_v;
        logic [7:0]    rd_byte;
    } core_s;

    core_s    core_d, core_q;
    card_st_e dec_nxt;
    logic     dec_ill, dec_load, dec_cid, dec_clr;
    rsp_e     dec_rsp;
    logic [7:0] src_byte;

    sdc_cmd_decode u_dec (
        .spi_i  (spi_mode),
        .app_i  (cmd_app),
        .idx_i  (cmd_idx),
        .cur_i  (core_q.st),
        .nxt_o  (dec_nxt),
        .ill_o  (dec_ill),
        .rsp_o  (dec_rsp),
        .load_o (dec_load),
        .cid_o  (dec_cid),
        .clr_o  (dec_clr)
    );

    sdc_reg_bytes #(
        .NBYTES  (NBYTES),
        .OW      (OW),
        .CSD_VAL (CSD_VAL),
        .CID_VAL (CID_VAL)
    ) u_bytes (
        .sel_cid_i (core_q.src_cid),
        .ofs_i     (core_q.ofs),
        .byte_o    (src_byte)
    );

    always_comb begin
        core_d       = core_q;
        core_d.rsp_v = 1'b0;
        core_d.rsp   = RSP_NONE;
        core_d.rd_v  = 1'b0;
        if (cmd_valid) begin
            core_d.st    = dec_nxt;
            core_d.ill   = dec_clr ? 1'b0 : (core_q.ill | dec_ill);
            core_d.rsp_v = 1'b1;
            core_d.rsp   = dec_rsp;
            if (dec_load) begin
                core_d.ofs     = '0;
                core_d.src_cid = dec_cid;
            end
        end else if (rd_req && core_q.st == ST_DATA) begin
            core_d.rd_v    = 1'b1;
            core_d.rd_byte = src_byte;
            if (core_q.ofs == OFS_LAST) begin
                core_d.st  = ST_TRAN;
                core_d.ofs = '0;
            end else begin
                core_d.ofs = core_q.ofs + OW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    always_comb begin
        card_status                  = '0;
        card_status[ILL_BIT]         = core_q.ill;
        card_status[ST_LSB +: 4]     = core_q.st;
    end

    assign rsp_valid  = core_q.rsp_v;
    assign rsp_type   = core_q.rsp;
    assign rd_valid   = core_q.rd_v;
    assign rd_data    = core_q.rd_byte;
    assign data_ready = (core_q.st == ST_DATA);

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        spi_mode,
    input logic        cmd_valid,
    input logic [5:0]  cmd_idx,
    input logic        cmd_app,
    input logic        rsp_valid,
    input logic [2:0]  rsp_type,
    input logic [31:0] card_status,
    input logic        rd_valid,
    input logic        data_ready
);

    p_status_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (card_status & ~32'h0040_1E00) == 32'h0);

    p_cmd0_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_app && cmd_idx == 6'd0 |=>
        rsp_valid && card_status[12:9] == 4'd0 && !card_status[22] &&
        rsp_type == ($past(spi_mode) ? 3'd1 : 3'd0));

    p_cmd1_tran_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_app && spi_mode && cmd_idx == 6'd1 |=>
        card_status[12:9] == 4'd4 && rsp_type == 3'd1);

    p_spi_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_app && spi_mode &&
        (cmd_idx inside {6'd2, 6'd3, 6'd4, 6'd6, 6'd7, 6'd11, 6'd15,
                         6'd24, 6'd25, 6'd26, 6'd27, 6'd42}) |=>
        card_status[22] && rsp_type == 3'd0 &&
        card_status[12:9] == $past(card_status[12:9]));

    p_read_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(data_ready));

    p_cmd_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rsp_valid));

endmodule

bind sdc_spi_core sdc_checker u_chk (.*);

// File: tb/sim_sdc_spi_core.sv
`timescale 1ns/1ps
module sim_sdc_spi_core;

    localparam logic [127:0] CSD_V = 128'h400E_0032_5B59_0000_1D8A_7F80_0A40_0001;
    localparam logic [127:0] CID_V = 128'h0353_4453_4430_3847_8012_3456_7800_C5A1;

    logic clk = 1'b0, rst_n = 1'b0, spi_mode = 1'b1;
    logic cmd_valid = 1'b0, cmd_app = 1'b0, rd_req = 1'b0;
    logic [5:0] cmd_idx = '0;
    logic rsp_valid, rd_valid, data_ready;
    logic [2:0] rsp_type;
    logic [31:0] card_status;
    logic [7:0] rd_data;

    always #4 clk = ~clk;

    sdc_spi_core #(.NBYTES(16), .CSD_VAL(CSD_V), .CID_VAL(CID_V)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .cmd_valid(cmd_valid),
        .cmd_idx(cmd_idx), .cmd_app(cmd_app), .rd_req(rd_req),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .card_status(card_status),
        .rd_valid(rd_valid), .rd_data(rd_data), .data_ready(data_ready));

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [3:0] m_st;
    logic m_ill, m_cid;
    int m_ofs;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[22] = m_ill;
        s[12:9] = m_st;
        return s;
    endfunction

    // Shadow model from the requirements: one step per command.
    task automatic model_cmd(input logic [5:0] ix, input logic app, output logic [2:0] rsp);
        logic ill = 1'b0;
        rsp = 3'd0;
        if (app) begin
            if (ix == 6'd41) begin
                if (spi_mode) begin m_st = 4'd4; rsp = 3'd1; end
                else if (m_st == 4'd0) begin m_st = 4'd1; rsp = 3'd3; end
                else ill = 1'b1;
            end else ill = 1'b1;
        end else begin
            case (ix)
                6'd0: begin m_st = 4'd0; m_ill = 1'b0; rsp = spi_mode ? 3'd1 : 3'd0; end
                6'd1: if (spi_mode) begin m_st = 4'd4; rsp = 3'd1; end else ill = 1'b1;
                6'd2: if (!spi_mode && m_st == 4'd1) begin m_st = 4'd2; rsp = 3'd2; end else ill = 1'b1;
                6'd3: if (!spi_mode && (m_st == 4'd2 || m_st == 4'd3)) begin m_st = 4'd3; rsp = 3'd4; end
                      else ill = 1'b1;
                6'd7: if (!spi_mode && m_st == 4'd3) begin m_st = 4'd4; rsp = 3'd1; end
                      else if (!spi_mode && m_st == 4'd4) begin m_st = 4'd3; rsp = 3'd1; end
                      else ill = 1'b1;
                6'd4, 6'd6, 6'd11, 6'd15, 6'd24, 6'd25, 6'd26, 6'd27, 6'd42:
                      if (spi_mode) ill = 1'b1; else rsp = 3'd1;
                6'd9, 6'd10:
                      if (spi_mode && m_st == 4'd4) begin
                          m_st = 4'd5; m_ofs = 0; m_cid = (ix == 6'd10); rsp = 3'd1;
                      end else if (!spi_mode && m_st == 4'd3) rsp = 3'd2;
                      else ill = 1'b1;
                6'd13: rsp = 3'd1;
                default: ill = 1'b1;
            endcase
        end
        if (ill) m_ill = 1'b1;
    endtask

    function automatic logic [7:0] exp_byte(int k);
        logic [127:0] v = m_cid ? CID_V : CSD_V;
        return v[8*(15-k) +: 8];
    endfunction

    // Drive on a falling edge, sample on the next one: one register stage.
    task automatic do_cmd(logic [5:0] ix, logic app, logic with_rd, string req);
        logic [2:0] er;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_idx = ix; cmd_app = app; rd_req = with_rd;
        model_cmd(ix, app, er);
        @(negedge clk);
        cmd_valid = 1'b0; rd_req = 1'b0; cmd_app = 1'b0;
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({req, " rsp_type"}, 32'(rsp_type), 32'(er));
        check({req, " status"}, card_status, exp_status());
        check({req, " data_ready"}, 32'(data_ready), 32'(m_st == 4'd5));
        if (with_rd) check("R9 read dropped", 32'(rd_valid), 32'd0);
    endtask

    task automatic do_rd(string req);
        logic ev;
        logic [7:0] eb;
        @(negedge clk);
        rd_req = 1'b1;
        ev = (m_st == 4'd5);
        eb = 8'h00;
        if (ev) begin
            eb = exp_byte(m_ofs);
            m_ofs++;
            if (m_ofs == 16) begin m_st = 4'd4; m_ofs = 0; end
        end
        @(negedge clk);
        rd_req = 1'b0;
        check({req, " rd_valid"}, 32'(rd_valid), 32'(ev));
        if (ev) check({req, " rd_data"}, 32'(rd_data), 32'(eb));
        check({req, " status"}, card_status, exp_status());
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd0);
    endtask

    task automatic do_reset(logic spi);
        @(negedge clk);
        rst_n = 1'b0; spi_mode = spi;
        m_st = 4'd0; m_ill = 1'b0; m_cid = 1'b0; m_ofs = 0;
        repeat (2) @(negedge clk);
        check("R1 reset status", card_status, 32'h0);
        check("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 reset rd_valid", 32'(rd_valid), 32'd0);
        check("R1 reset data_ready", 32'(data_ready), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic random_run(int n);
        logic [5:0] pool [12] = '{6'd0, 6'd1, 6'd9, 6'd10, 6'd13, 6'd2,
                                  6'd3, 6'd7, 6'd24, 6'd41, 6'd55, 6'd11};
        for (int i = 0; i < n; i++) begin
            int unsigned r = $urandom;
            if (r[1:0] == 2'd0 || (m_st == 4'd5 && r[2])) begin
                do_rd("R8 random read");
            end else begin
                logic [5:0] ix = r[3] ? pool[r[7:4] % 12] : 6'(r[13:8]);
                logic app = (r[18:16] == 3'd0) || (ix == 6'd41 && r[19]);
                do_cmd(ix, app, r[20] && r[21], "R10 random cmd");
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd7351);
        // SPI phase
        do_reset(1'b1);
        do_cmd(6'd9, 1'b0, 1'b0, "R7 read reg while idle");
        do_cmd(6'd13, 1'b0, 1'b0, "R11 flag held");
        do_cmd(6'd0, 1'b0, 1'b0, "R2 reset cmd spi");
        do_cmd(6'd1, 1'b0, 1'b0, "R3 opcond spi");
        foreach (pool_rej[i]) do_cmd(pool_rej[i], 1'b0, 1'b0, "R5 spi refuse");
        do_cmd(6'd50, 1'b0, 1'b0, "R10 unknown");
        do_cmd(6'd0, 1'b0, 1'b0, "R2 clear");
        do_cmd(6'd41, 1'b1, 1'b0, "R4 app op spi");
        do_rd("R8 read outside data");
        do_cmd(6'd9, 1'b0, 1'b0, "R7 csd load");
        for (int k = 0; k < 16; k++) do_rd("R8 csd byte");
        do_rd("R8 read after end");
        do_cmd(6'd10, 1'b0, 1'b0, "R7 cid load");
        for (int k = 0; k < 3; k++) do_rd("R8 cid byte");
        do_cmd(6'd13, 1'b0, 1'b1, "R9 cmd with read");
        do_rd("R9 offset kept");
        do_cmd(6'd7, 1'b1, 1'b0, "R10 unknown app");
        do_cmd(6'd0, 1'b0, 1'b0, "R2 reset from data");
        random_run(600);
        // native phase
        do_reset(1'b0);
        do_cmd(6'd1, 1'b0, 1'b0, "R3 opcond native illegal");
        do_cmd(6'd0, 1'b0, 1'b0, "R2 reset cmd native");
        do_cmd(6'd41, 1'b1, 1'b0, "R4 app op native");
        do_cmd(6'd41, 1'b1, 1'b0, "R4 app op out of state");
        do_cmd(6'd2, 1'b0, 1'b0, "R6 all id");
        do_cmd(6'd3, 1'b0, 1'b0, "R6 address");
        do_cmd(6'd9, 1'b0, 1'b0, "R6 csd long");
        do_cmd(6'd7, 1'b0, 1'b0, "R6 select");
        do_cmd(6'd11, 1'b0, 1'b0, "R6 accepted");
        do_cmd(6'd9, 1'b0, 1'b0, "R6 csd out of state");
        do_cmd(6'd7, 1'b0, 1'b0, "R6 deselect");
        random_run(600);
        finish_run();
    end

    logic [5:0] pool_rej [12] = '{6'd2, 6'd3, 6'd4, 6'd6, 6'd7, 6'd11,
                                  6'd15, 6'd26, 6'd24, 6'd25, 6'd27, 6'd42};

endmodule